// File: doc/BRIEF.md
# Byte-Level I2C Serial EEPROM Slave

This block is a synthesizable model of a serial EEPROM that sits behind an I2C bit engine. It does not touch the wires. It takes decoded bus events: start, repeated start and stop, each received byte, and the ACK or NACK the master returned after a byte the model sent. It answers with an acknowledge pulse for each byte it accepts and presents read data for the bit engine to shift out.

The model compares each control byte against its configured device code and chip-select strap. A write control byte is followed by one or more word-address bytes, sent high byte first, which load an internal address counter. Data bytes that follow are stored at the counter. During these writes the counter wraps inside the current page. A read control byte returns the byte at the counter. The master may send it straight after a start for a current-address read, or after a repeated start that follows a word address for a random read. While the master ACKs each byte, the counter steps through the whole array and the model returns the next byte. The array depth, page size, address byte count, device code and chip-select wiring are parameters.

Top module: `seeprom_slave`

## Requirements
- R1: A control byte is acknowledged (ack_out high for one cycle, the cycle after the byte) only when bits 7..4 equal the device code (default 4'b1010) and, for each of the NUM_CS lowest strap positions i, bit i+1 equals strap bit i. Strap positions at or above NUM_CS are not compared.
- R2: Control bit 0 selects the direction, where 1 means read. A matching read control byte raises tx_valid the cycle after it, with tx_byte showing the array byte at the counter. Bytes received while tx_valid is high are not acknowledged.
- R3: After a matching write control byte, the next ADDR_BYTES bytes are acknowledged and load the counter, high byte first. The counter keeps the address modulo DEPTH.
- R4: Every later data byte of a write is acknowledged and stored at the counter. The counter then increments only in its low log2(PAGE) bits, so a page write wraps to the start of its own page.
- R5: A repeated start, then a matching read control byte after the word address, returns the byte at that address and changes no array content.
- R6: A read control byte sent directly after a start returns the byte at the current counter value, which is one past the last byte written or read.
- R7: Each master ACK during a read advances the counter by one modulo DEPTH and presents the next byte. A master NACK also advances the counter and drops tx_valid. After that, no byte is acknowledged until the next start.
- R8: After a control byte that does not match, no byte is acknowledged and no array content changes until the next start or repeated start.
- R9: After reset, ack_out and tx_valid are low and no byte is acknowledged before a start.
- R10: A stop ends any transfer. tx_valid falls the next cycle and bytes after the stop are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_start | input | 1 | Start condition seen, one-cycle pulse |
| ev_rstart | input | 1 | Repeated start seen, one-cycle pulse |
| ev_stop | input | 1 | Stop condition seen, one-cycle pulse |
| rx_valid | input | 1 | A byte from the master is complete, one-cycle pulse |
| rx_byte | input | 8 | Byte received from the master |
| mack_valid | input | 1 | Master acknowledge bit after a read byte is sampled, one-cycle pulse |
| mack_nack | input | 1 | With mack_valid: 1 = master NACK, 0 = master ACK |
| ack_out | output | 1 | Model acknowledges the previous byte |
| tx_valid | output | 1 | Model is in a read transfer and tx_byte is valid |
| tx_byte | output | 8 | Byte to shift out to the master |

## Verification
The bench sends all 256 control byte values under a reduced configuration. This separates the device-code compare, the compared strap bits, the ignored strap bit and the direction bit. It fills the whole array with an arithmetic pattern through byte writes. It then reads every address back, first with a random read and then with a current-address read, which confirms that the counter advanced past the byte just returned. Further runs cover a sequential read that crosses the top of the array, and a page write started near a page end whose wrapped bytes must leave the neighbouring page untouched. Last come out-of-range addresses, a non-matching write, and bytes that arrive during a read, after a NACK or after a stop, all of which must go unacknowledged and leave the contents unchanged.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CTRL  = 3'd1,
    ST_WADDR = 3'd2,
    ST_WDATA = 3'd3,
    ST_RDATA = 3'd4,
    ST_HOLD  = 3'd5
  } seep_state_e;
endpackage

// File: rtl/seeprom_ctrl_match.sv
module seeprom_ctrl_match #(
  parameter logic [3:0] DEV_CODE = 4'b1010,
  parameter int         NUM_CS   = 3,
  parameter logic [2:0] CS_STRAP = 3'b000
) (
  input  logic [7:0] ctrl_byte,
  output logic       hit,
  output logic       is_read
);
  logic [2:0] cs_ok;

  for (genvar i = 0; i < 3; i++) begin : g_cs
    if (i < NUM_CS) begin : g_cmp
      assign cs_ok[i] = (ctrl_byte[i+1] == CS_STRAP[i]);
    end else begin : g_free
      assign cs_ok[i] = 1'b1;
    end
  end

  assign hit     = (ctrl_byte[7:4] == DEV_CODE) && (&cs_ok);
  assign is_read = ctrl_byte[0];
endmodule

// File: rtl/seeprom_addr_ctr.sv
module seeprom_addr_ctr #(
  parameter int AW = 8,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [7:0]    load_byte,
  input  logic          inc_page,
  input  logic          inc_full,
  output logic [AW-1:0] addr_q
);
  logic [AW+7:0] shifted;
  logic [AW-1:0] addr_page_inc;
  logic [AW-1:0] addr_d;

  assign shifted = {addr_q, load_byte};

  if (PW < AW) begin : g_page_split
    logic [PW-1:0] low_inc;
    assign low_inc       = addr_q[PW-1:0] + 1'b1;
    assign addr_page_inc = {addr_q[AW-1:PW], low_inc};
  end else begin : g_page_whole
    assign addr_page_inc = addr_q + 1'b1;
  end

  always_comb begin
    addr_d = addr_q;
    if (load_en) begin
      addr_d = shifted[AW-1:0];
    end else if (inc_page) begin
      addr_d = addr_page_inc;
    end else if (inc_full) begin
      addr_d = addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (load_en || inc_page || inc_full) begin
      addr_q <= addr_d;
    end
  end
endmodule

// File: rtl/seeprom_array.sv
module seeprom_array #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wr_data,
  output logic [7:0]    rd_data
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      cells[addr] <= wr_data;
    end
  end

  assign rd_data = cells[addr];
endmodule

// File: rtl/seeprom_slave.sv
module seeprom_slave
  import seeprom_pkg::*;
#(
  parameter int         DEPTH      = 256,
  parameter int         PAGE       = 16,
  parameter int         ADDR_BYTES = 1,
  parameter logic [3:0] DEV_CODE   = 4'b1010,
  parameter int         NUM_CS     = 3,
  parameter logic [2:0] CS_STRAP   = 3'b000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_start,
  input  logic       ev_rstart,
  input  logic       ev_stop,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       mack_valid,
  input  logic       mack_nack,
  output logic       ack_out,
  output logic       tx_valid,
  output logic [7:0] tx_byte
);
  localparam int AW  = $clog2(DEPTH);
  localparam int PW  = $clog2(PAGE);
  localparam int ABW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam logic [ABW-1:0] AB_LAST = ABW'(ADDR_BYTES - 1);

  logic [1:0]    rst_sync;
  logic          rst_i_n;
  seep_state_e   st_q, st_d;
  logic [ABW-1:0] ab_q, ab_d;
  logic          ack_q, ack_d;
  logic          ctrl_hit, ctrl_rd;
  logic          ld_addr, inc_page, inc_full, wr_en;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_i_n = rst_sync[1];

  seeprom_ctrl_match #(
    .DEV_CODE(DEV_CODE), .NUM_CS(NUM_CS), .CS_STRAP(CS_STRAP)
  ) u_match (
    .ctrl_byte(rx_byte), .hit(ctrl_hit), .is_read(ctrl_rd)
  );

  seeprom_addr_ctr #(.AW(AW), .PW(PW)) u_ctr (
    .clk(clk), .rst_n(rst_i_n), .load_en(ld_addr), .load_byte(rx_byte),
    .inc_page(inc_page), .inc_full(inc_full), .addr_q(addr_q)
  );

  seeprom_array #(.DEPTH(DEPTH)) u_arr (
    .clk(clk), .wr_en(wr_en), .addr(addr_q), .wr_data(rx_byte),
    .rd_data(tx_byte)
  );

  always_comb begin
    st_d     = st_q;
    ab_d     = ab_q;
    ack_d    = 1'b0;
    ld_addr  = 1'b0;
    inc_page = 1'b0;
    inc_full = 1'b0;
    wr_en    = 1'b0;
    if (ev_start || ev_rstart) begin
      st_d = ST_CTRL;
    end else if (ev_stop) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_CTRL: begin
          if (rx_valid) begin
            if (ctrl_hit) begin
              ack_d = 1'b1;
              ab_d  = '0;
              st_d  = ctrl_rd ? ST_RDATA : ST_WADDR;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        ST_WADDR: begin
          if (rx_valid) begin
            ack_d   = 1'b1;
            ld_addr = 1'b1;
            if (ab_q == AB_LAST) begin
              st_d = ST_WDATA;
            end else begin
              ab_d = ab_q + 1'b1;
            end
          end
        end
        ST_WDATA: begin
          if (rx_valid) begin
            ack_d    = 1'b1;
            wr_en    = 1'b1;
            inc_page = 1'b1;
          end
        end
        ST_RDATA: begin
          if (mack_valid) begin
            inc_full = 1'b1;
            if (mack_nack) begin
              st_d = ST_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q  <= ST_IDLE;
      ab_q  <= '0;
      ack_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ab_q  <= ab_d;
      ack_q <= ack_d;
    end
  end

  assign ack_out  = ack_q;
  assign tx_valid = (st_q == ST_RDATA);
endmodule

// File: rtl/seeprom_chk.sv
module seeprom_chk
  import seeprom_pkg::*;
#(
  parameter int AW = 8,
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_start,
  input logic          ev_rstart,
  input logic          ev_stop,
  input logic          rx_valid,
  input logic          mack_valid,
  input logic          mack_nack,
  input logic          ack_out,
  input logic          tx_valid,
  input logic [AW-1:0] addr,
  input seep_state_e   st
);
  logic quiet;
  assign quiet = !ev_start && !ev_rstart && !ev_stop;

  AST_ACK_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_out |-> $past(rx_valid)); // R1

  AST_NO_ACK_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && rx_valid && quiet) |=> !ack_out); // R2

  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WDATA && rx_valid && quiet) |=> ((addr >> PW) == ($past(addr) >> PW))); // R4

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RDATA && mack_valid && quiet) |=> (addr == AW'($past(addr) + 1'b1))); // R7

  AST_NACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && mack_valid && mack_nack && quiet) |=> !tx_valid); // R7

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (!tx_valid && st == ST_IDLE)); // R10
endmodule

bind seeprom_slave seeprom_chk #(.AW(AW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_i_n), .ev_start(ev_start), .ev_rstart(ev_rstart),
  .ev_stop(ev_stop), .rx_valid(rx_valid), .mack_valid(mack_valid),
  .mack_nack(mack_nack), .ack_out(ack_out), .tx_valid(tx_valid),
  .addr(addr_q), .st(st_q)
);

// File: tb/seeprom_slave_bench.sv
module seeprom_slave_bench;
  localparam int CLK_P = 10;
  localparam int DEPTH = 64;
  localparam int PAGE  = 8;
  localparam logic [7:0] CW = 8'hA4;
  localparam logic [7:0] CR = 8'hA5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_start = 1'b0, ev_rstart = 1'b0, ev_stop = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic mack_valid = 1'b0, mack_nack = 1'b0;
  logic ack_out, tx_valid;
  logic [7:0] tx_byte;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  seeprom_slave #(
    .DEPTH(DEPTH), .PAGE(PAGE), .ADDR_BYTES(1), .DEV_CODE(4'b1010),
    .NUM_CS(2), .CS_STRAP(3'b010)
  ) u_seeprom_slave (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_rstart(ev_rstart),
    .ev_stop(ev_stop), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .mack_valid(mack_valid), .mack_nack(mack_nack), .ack_out(ack_out),
    .tx_valid(tx_valid), .tx_byte(tx_byte)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk) ev_start = 1'b1;
    @(negedge clk) ev_start = 1'b0;
  endtask

  task automatic do_rstart();
    @(negedge clk) ev_rstart = 1'b1;
    @(negedge clk) ev_rstart = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk) ev_stop = 1'b1;
    @(negedge clk) ev_stop = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    @(negedge clk) begin rx_valid = 1'b1; rx_byte = b; end
    @(negedge clk) begin rx_valid = 1'b0; ack = ack_out; end
  endtask

  task automatic master_ack(input logic nack);
    @(negedge clk) begin mack_valid = 1'b1; mack_nack = nack; end
    @(negedge clk) mack_valid = 1'b0;
  endtask

  task automatic write_bytes(input int a, input logic [7:0] d[], input string req);
    logic k;
    do_start();
    send(CW, k); check(req, k, 1);
    send(8'(a), k); check("R3 address ack", k, 1);
    foreach (d[i]) begin
      send(d[i], k); check(req, k, 1);
    end
    do_stop();
  endtask

  task automatic random_read(input int a, output logic [7:0] v);
    logic k;
    do_start();
    send(CW, k);
    send(8'(a), k);
    do_rstart();
    send(CR, k);
    v = tx_byte;
    master_ack(1'b1);
    do_stop();
  endtask

  task automatic cur_read(output logic [7:0] v);
    logic k;
    do_start();
    send(CR, k);
    v = tx_byte;
    master_ack(1'b1);
    do_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic k;
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9: reset state, and a byte before any start is not acked
    check("R9 ack_out after reset", ack_out, 0);
    check("R9 tx_valid after reset", tx_valid, 0);
    send(CW, k);
    check("R9 byte before start", k, 0);

    // R1 R2: sweep every control byte value
    for (int b = 0; b < 256; b++) begin
      logic m;
      m = (b[7:4] == 4'b1010) && (b[2:1] == 2'b10);
      do_start();
      send(8'(b), k);
      check("R1 control match", k, m);
      check("R2 direction", tx_valid, m && b[0]);
      do_stop();
    end

    // R4: fill the array with single-byte writes
    for (int a = 0; a < DEPTH; a++) begin
      logic [7:0] d[];
      d = new[1];
      d[0] = pat(a);
      write_bytes(a, d, "R4 byte write ack");
    end

    // R5 R6: random read then current address read for every address
    for (int a = 0; a < DEPTH; a++) begin
      random_read(a, v);
      check("R5 random read", v, pat(a));
      cur_read(v);
      check("R6 current address read", v, pat((a + 1) % DEPTH));
    end

    // R7: sequential read across the top of the array
    do_start();
    send(CW, k);
    send(8'd60, k);
    do_rstart();
    send(CR, k);
    for (int i = 0; i < 8; i++) begin
      check("R7 sequential data", tx_byte, pat((60 + i) % DEPTH));
      check("R7 tx_valid during read", tx_valid, 1);
      master_ack(i == 7);
    end
    check("R7 tx_valid after nack", tx_valid, 0);
    send(8'h33, k);
    check("R7 byte after nack ignored", k, 0);
    do_stop();

    // R4: page write from 13 wraps inside page 8..15
    begin
      logic [7:0] d[];
      d = new[5];
      foreach (d[i]) d[i] = 8'hC0 | 8'(i);
      write_bytes(13, d, "R4 page write ack");
    end
    do_start();
    send(CW, k);
    send(8'd8, k);
    do_rstart();
    send(CR, k);
    for (int i = 0; i < 9; i++) begin
      logic [7:0] e;
      int ad;
      ad = 8 + i;
      if (ad == 8 || ad == 9) e = 8'hC3 + 8'(ad - 8);
      else if (ad >= 13 && ad <= 15) e = 8'hC0 + 8'(ad - 13);
      else e = pat(ad);
      check("R4 page wrap content", tx_byte, e);
      master_ack(i == 8);
    end
    do_stop();
    cur_read(v);
    check("R6 counter after sequential read", v, pat(17));

    // R3: address modulo DEPTH
    begin
      logic [7:0] d[];
      d = new[1];
      d[0] = 8'h99;
      write_bytes(8'h47, d, "R3 wrapped write ack");
    end
    random_read(7, v);
    check("R3 write to 0x47 lands at 7", v, 8'h99);
    random_read(8'h87, v);
    check("R3 read at 0x87 aliases 7", v, 8'h99);

    // R8: non-matching write control byte
    do_start();
    send(8'hB4, k);
    check("R8 bad code not acked", k, 0);
    send(8'd3, k);
    check("R8 following byte not acked", k, 0);
    send(8'hEE, k);
    check("R8 data not acked", k, 0);
    do_stop();
    random_read(3, v);
    check("R8 content unchanged", v, pat(3));

    // R2: byte during read not acked and not stored
    do_start();
    send(CR, k);
    send(8'h55, k);
    check("R2 byte during read ignored", k, 0);
    master_ack(1'b1);
    do_stop();

    // R10: bytes after stop in write data phase
    do_start();
    send(CW, k);
    send(8'd20, k);
    do_stop();
    check("R10 tx_valid after stop", tx_valid, 0);
    send(8'h11, k);
    check("R10 byte after stop ignored", k, 0);
    random_read(20, v);
    check("R10 content unchanged", v, pat(20));

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule